// File: doc/BRIEF.md
# Transmit Start Gating Logic

This block decides when a network transmitter may begin the preamble of a queued packet. It reads a 2-bit start point code, a no-underflow mode bit, the byte count now held in the MAC transmit FIFO, a flag saying the end-of-packet marker is in that FIFO, and a flag from the DMA engine saying the whole packet has been fetched on chip. The fetched packet may be spread over the bus FIFO, a local SRAM and the MAC FIFO. The block raises a one-cycle start pulse once for each packet. It then holds off until the transmitter reports that the frame has ended.

Without no-underflow mode, only the start point threshold in the MAC FIFO gates the start. With no-underflow mode, the complete-packet flag must also be set. In that mode the full-packet code has no meaning of its own, so it falls back to the smallest threshold.

Top module: `tx_start_gate`

## Requirements
- R1: After reset, `start_o` is 0 and the block is armed, ready to evaluate a packet.
- R2: With `no_uflow_i`=0 and `start_code_i` equal to 0, 1 or 2, `start_o` pulses in the cycle after a packet is pending and `fifo_bytes_i` reaches 4, 64 or 128 bytes respectively.
- R3: No start occurs while `fifo_bytes_i` is below the selected threshold and `eop_in_fifo_i` is 0. In every mode, a start requires at least 4 bytes or the end-of-packet marker.
- R4: When `eop_in_fifo_i`=1, the threshold counts as met whatever the byte count (short packets).
- R5: With `no_uflow_i`=0 and `start_code_i`=3, a start requires `eop_in_fifo_i`=1. The byte count alone never suffices.
- R6: With `no_uflow_i`=1, a start also requires `pkt_fetched_i`=1, in addition to the threshold condition.
- R7: With `no_uflow_i`=1 and `start_code_i`=3, the threshold is 4 bytes (or the end-of-packet marker), gated by `pkt_fetched_i`.
- R8: Exactly one single-cycle pulse is issued per packet. No further pulse occurs until `tx_done_i` is seen, even if the conditions stay true.
- R9: A `tx_done_i` pulse re-arms the block, so a pending packet that meets its conditions starts one cycle after the re-arm.
- R10: With `pkt_pending_i`=0, no start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_code_i | input | 2 | Start point code (0:4 B, 1:64 B, 2:128 B, 3:full packet) |
| no_uflow_i | input | 1 | No-underflow mode |
| fifo_bytes_i | input | CNT_W | Bytes now in the MAC transmit FIFO |
| eop_in_fifo_i | input | 1 | End-of-packet marker present in the MAC FIFO |
| pkt_fetched_i | input | 1 | Whole packet fetched on chip |
| pkt_pending_i | input | 1 | A packet is queued for transmission |
| tx_done_i | input | 1 | Transmission of the current frame has ended |
| start_o | output | 1 | One-cycle start-preamble pulse |

## Verification
The bench sweeps every code and mode against byte counts on both sides of each threshold (3/4/5, 63/64/65, 127/128/129), with every combination of end-of-packet and fetched flags. Each sweep point is compared against an arithmetic model. An off-by-one comparator would start at 63 or withhold at 128. A design that let code 3 compare bytes would start full-packet frames early. Ignoring the fetched flag in no-underflow mode would risk underflow. A separate sequence holds the start conditions true for several cycles to catch repeated pulses, and checks that `tx_done_i` re-arms the block.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic {ST_ARMED = 1'b0, ST_BUSY = 1'b1} tsg_state_e;
  localparam int unsigned CODE_N    = 4;
  localparam logic [1:0]  CODE_FULL = 2'd3;
endpackage

// File: rtl/tsg_level.sv
module tsg_level import tsg_pkg::*; #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned THR0  = 4,
  parameter int unsigned THR1  = 64,
  parameter int unsigned THR2  = 128
) (
  input  logic [1:0]       code_i,
  input  logic             no_uflow_i,
  input  logic [CNT_W-1:0] bytes_i,
  input  logic             eop_i,
  input  logic             fetched_i,
  output logic             go_o
);
  localparam logic [CNT_W-1:0] THR_TAB [CODE_N-1] = '{CNT_W'(THR0), CNT_W'(THR1), CNT_W'(THR2)};

  logic [CODE_N-1:0] hit;
  logic              lvl_met;

  for (genvar g = 0; g < CODE_N - 1; g++) begin : g_cmp
    assign hit[g] = bytes_i >= THR_TAB[g];
  end
  // full-packet code never compares bytes
  assign hit[CODE_N-1] = 1'b0;

  always_comb begin
    if (code_i == CODE_FULL && no_uflow_i) lvl_met = eop_i || hit[0];
    else                                   lvl_met = eop_i || hit[code_i];
  end

  assign go_o = lvl_met && (!no_uflow_i || fetched_i);

  always_comb begin
    if (go_o && !eop_i) assert_min_bytes_R3: assert (bytes_i >= CNT_W'(THR0));
    if (go_o && code_i == CODE_FULL && !no_uflow_i) assert_full_needs_eop_R5: assert (eop_i);
  end
endmodule

// File: rtl/tsg_seq.sv
module tsg_seq import tsg_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic go_i,
  input  logic done_i,
  output logic start_o
);
  tsg_state_e state_q, state_d;
  logic       fire;

  assign fire = (state_q == ST_ARMED) && pending_i && go_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: if (fire)   state_d = ST_BUSY;
      ST_BUSY:  if (done_i) state_d = ST_ARMED;
      default:              state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      start_o <= 1'b0;
    end else begin
      state_q <= state_d;
      start_o <= fire;
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && !done_i) |=> !start_o);
  assert_needs_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_i |=> !start_o);
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned THR0  = 4,
  parameter int unsigned THR1  = 64,
  parameter int unsigned THR2  = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       start_code_i,
  input  logic             no_uflow_i,
  input  logic [CNT_W-1:0] fifo_bytes_i,
  input  logic             eop_in_fifo_i,
  input  logic             pkt_fetched_i,
  input  logic             pkt_pending_i,
  input  logic             tx_done_i,
  output logic             start_o
);
  logic go;

  tsg_level #(.CNT_W(CNT_W), .THR0(THR0), .THR1(THR1), .THR2(THR2)) u_level (
    .code_i     (start_code_i),
    .no_uflow_i (no_uflow_i),
    .bytes_i    (fifo_bytes_i),
    .eop_i      (eop_in_fifo_i),
    .fetched_i  (pkt_fetched_i),
    .go_o       (go)
  );

  tsg_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pkt_pending_i),
    .go_i      (go),
    .done_i    (tx_done_i),
    .start_o   (start_o)
  );

  assert_nu_fetched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_uflow_i && !pkt_fetched_i) |=> !start_o);
  assert_start_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eop_in_fifo_i && fifo_bytes_i < CNT_W'(THR0)) |=> !start_o);
endmodule

// File: tb/tb_tx_start_gate.sv
module tb_tx_start_gate;
  localparam int CNT_W = 11;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       code = '0;
  logic             nu = 1'b0;
  logic [CNT_W-1:0] bytes = '0;
  logic             eop = 1'b0;
  logic             fetched = 1'b0;
  logic             pending = 1'b0;
  logic             done = 1'b0;
  logic             start;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tx_start_gate #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_code_i(code), .no_uflow_i(nu),
    .fifo_bytes_i(bytes), .eop_in_fifo_i(eop), .pkt_fetched_i(fetched),
    .pkt_pending_i(pending), .tx_done_i(done), .start_o(start));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s code=%0d nu=%0d bytes=%0d eop=%0d fet=%0d act=%0b exp=%0b",
               req, code, nu, bytes, eop, fetched, act, exp);
    end
  endtask

  function automatic logic model(input int c, input int n, input int b, input int e, input int f);
    int thr;
    logic met;
    thr = (c == 0) ? 4 : (c == 1) ? 64 : (c == 2) ? 128 : 0;
    if (c == 3) met = (e != 0) || ((n != 0) && b >= 4); // R5 R7
    else        met = (e != 0) || (b >= thr);            // R2 R3 R4
    return met && ((n == 0) || (f != 0));                // R6
  endfunction

  task automatic rearm();
    @(negedge clk); pending = 1'b0; done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int blist [11] = '{0, 3, 4, 5, 63, 64, 65, 127, 128, 129, 300};
    repeat (3) @(negedge clk);
    check("R1", start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", start, 1'b0);

    // sweep R2 R3 R4 R5 R6 R7
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 2; n++)
        for (int bi = 0; bi < 11; bi++)
          for (int e = 0; e < 2; e++)
            for (int f = 0; f < 2; f++) begin
              rearm();
              code = 2'(c); nu = n[0]; bytes = CNT_W'(blist[bi]);
              eop = e[0]; fetched = f[0]; pending = 1'b1;
              @(negedge clk);
              check(c == 3 ? (n != 0 ? "R7" : "R5") : (n != 0 ? "R6" : "R2"),
                    start, model(c, n, blist[bi], e, f));
            end

    // R10: conditions met, nothing pending
    rearm();
    code = 2'd0; nu = 1'b0; bytes = 11'd200; eop = 1'b1; fetched = 1'b1; pending = 1'b0;
    repeat (3) begin @(negedge clk); check("R10", start, 1'b0); end

    // R8: one pulse only while conditions persist
    pending = 1'b1;
    @(negedge clk); check("R8", start, 1'b1);
    repeat (4) begin @(negedge clk); check("R8", start, 1'b0); end

    // R9: re-arm by tx_done, start follows
    done = 1'b1;
    @(negedge clk); check("R9", start, 1'b0);
    done = 1'b0;
    @(negedge clk); check("R9", start, 1'b1);
    @(negedge clk); check("R8", start, 1'b0);

    // R2 growing FIFO: pulse exactly one cycle after crossing 64
    rearm();
    code = 2'd1; eop = 1'b0; fetched = 1'b0; bytes = 11'd60; pending = 1'b1;
    for (int b = 61; b <= 66; b++) begin
      @(negedge clk);
      check("R2", start, (b - 1) == 64 ? 1'b1 : 1'b0);
      bytes = CNT_W'(b);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule